// File: doc/BRIEF.md
# Dual-Port Instruction Queue

This block is a small in-order buffer between an instruction fetch stage and a dispatch stage. On every clock it can take in zero, one or two fetched instruction words and release zero, one or two of its oldest words to dispatch. Fetch is told how many entries are free, so it only offers what fits. Dispatch sees the two oldest entries, each with its own valid flag. It reports how many of them it consumed in the same cycle.

A hold input stops dispatch, for example while a register dependency or a serializing instruction is pending. A flush input, used after a mispredicted branch, empties the queue in one clock. Entries live in a circular buffer of six slots. Its read and write pointers wrap modulo the depth.

Top module: `iq_dual_queue`

## Requirements
- R1: After a synchronous reset, `free_o` reads 6 and both head valid outputs read 0.
- R2: `enq_cnt_i` (0, 1 or 2) writes that many words in one clock: `enq_data0_i` when the count is at least 1, and `enq_data1_i` when it is 2. The word on `enq_data0_i` is older than the word on `enq_data1_i`. Written words can be seen on the head outputs from the cycle after the write edge.
- R3: `free_o` always equals 6 minus the number of stored entries. `enq_cnt_i` must never exceed `free_o`.
- R4: While `deq_hold_i` is 1, both head valid outputs read 0 and `deq_cnt_i` is ignored, so no entry leaves the queue.
- R5: With hold low, `deq_cnt_i` (0, 1 or 2) removes that many of the oldest entries at the clock edge. It must never exceed the number of valid head outputs.
- R6: Enqueue and dequeue may happen in the same cycle. Occupancy then changes by the enqueue count minus the dequeue count.
- R7: Program order is kept, including when the pointers wrap past slot 5. `head0_data_o` always holds the oldest entry and `head1_data_o` the next one. `head1_vld_o` is never 1 while `head0_vld_o` is 0.
- R8: When `flush_i` is 1 at a clock edge, the queue is empty after that edge (`free_o` = 6), and any enqueue offered in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Empties the queue and drops this cycle's enqueue |
| enq_cnt_i | input | 2 | Number of words offered by fetch (0 to 2) |
| enq_data0_i | input | 32 | Older fetched word |
| enq_data1_i | input | 32 | Younger fetched word |
| free_o | output | 3 | Number of free entries (0 to 6) |
| deq_hold_i | input | 1 | Blocks dispatch |
| deq_cnt_i | input | 2 | Number of head entries taken by dispatch (0 to 2) |
| head0_data_o | output | 32 | Oldest entry |
| head0_vld_o | output | 1 | `head0_data_o` is valid |
| head1_data_o | output | 32 | Second-oldest entry |
| head1_vld_o | output | 1 | `head1_data_o` is valid |

## Verification
Fetch writes and dispatch reads can land on the same clock edge. The same is true of a flush and a fetch write, and of a hold and a nonzero dispatch count.

Each of these overlaps is driven on purpose:
- A queue-model loop offers the largest legal enqueue and dequeue counts together for many cycles, so the write pointer passes the read pointer's slot and both wrap.
- A flush arrives with two words offered in the same cycle.
- Hold is raised while dispatch claims two entries.

After every edge, the free count and both head words with their valid flags are compared with a bench-side model. The model removes entries first and then appends the new ones.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int LANES = 2;
  typedef logic [1:0] lane_cnt_t;
endpackage

// File: rtl/iq_ptr_ctrl.sv
module iq_ptr_ctrl
  import iq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_i,
  input  logic          hold_i,
  input  lane_cnt_t     enq_cnt_i,
  input  lane_cnt_t     deq_cnt_i,
  output lane_cnt_t     enq_go_o,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] rd_ptr_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] free_o
);
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q, free_q, cnt_nx;
  lane_cnt_t     deq_go;

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input lane_cnt_t n);
    int s;
    s = int'(p) + int'(n);
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  assign enq_go_o = flush_i ? 2'd0 : enq_cnt_i;
  assign deq_go   = hold_i  ? 2'd0 : deq_cnt_i;
  assign cnt_nx   = cnt_q + CW'(enq_go_o) - CW'(deq_go);

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      free_q <= CW'(DEPTH);
    end else begin
      wr_q   <= adv(wr_q, enq_go_o);
      rd_q   <= adv(rd_q, deq_go);
      cnt_q  <= cnt_nx;
      free_q <= CW'(DEPTH) - cnt_nx;
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign cnt_o    = cnt_q;
  assign free_o   = free_q;

  // R3: fetch never offers more than fits
  p_enq_fits_r3: assert property (@(posedge clk) disable iff (rst)
    !flush_i |-> CW'(enq_cnt_i) <= free_q);
  // R5: dispatch never takes more than is stored
  p_deq_fits_r5: assert property (@(posedge clk) disable iff (rst)
    !hold_i |-> CW'(deq_cnt_i) <= cnt_q);
  // R6: occupancy moves by enqueue minus dequeue
  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!flush_i && !hold_i) |=> cnt_q == $past(cnt_q) + CW'($past(enq_cnt_i)) - CW'($past(deq_cnt_i)));
  // R8: flush empties the queue in one edge
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (cnt_q == '0) && (free_q == CW'(DEPTH)));
endmodule

// File: rtl/iq_store.sv
module iq_store
  import iq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  lane_cnt_t                  we_cnt_i,
  input  logic [PW-1:0]              wr_ptr_i,
  input  logic [LANES-1:0][DATA_W-1:0] wdata_i,
  input  logic [PW-1:0]              rd_ptr_i,
  output logic [LANES-1:0][DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [PW-1:0] slot(input logic [PW-1:0] p, input int n);
    int s;
    s = int'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (int'(we_cnt_i) > l) mem[slot(wr_ptr_i, l)] <= wdata_i[l];
    end
    assign rdata_o[l] = mem[slot(rd_ptr_i, l)];
  end
endmodule

// File: rtl/iq_dual_queue.sv
module iq_dual_queue
  import iq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic [1:0]        enq_cnt_i,
  input  logic [DATA_W-1:0] enq_data0_i,
  input  logic [DATA_W-1:0] enq_data1_i,
  output logic [CW-1:0]     free_o,
  input  logic              deq_hold_i,
  input  logic [1:0]        deq_cnt_i,
  output logic [DATA_W-1:0] head0_data_o,
  output logic              head0_vld_o,
  output logic [DATA_W-1:0] head1_data_o,
  output logic              head1_vld_o
);
  lane_cnt_t                    enq_go;
  logic [PW-1:0]                wr_ptr, rd_ptr;
  logic [CW-1:0]                cnt;
  logic [LANES-1:0][DATA_W-1:0] wdata, rdata;

  iq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .flush_i(flush_i), .hold_i(deq_hold_i),
    .enq_cnt_i(enq_cnt_i), .deq_cnt_i(deq_cnt_i), .enq_go_o(enq_go),
    .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr), .cnt_o(cnt), .free_o(free_o)
  );

  assign wdata[0] = enq_data0_i;
  assign wdata[1] = enq_data1_i;

  iq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we_cnt_i(enq_go), .wr_ptr_i(wr_ptr), .wdata_i(wdata),
    .rd_ptr_i(rd_ptr), .rdata_o(rdata)
  );

  assign head0_data_o = rdata[0];
  assign head1_data_o = rdata[1];
  assign head0_vld_o  = !deq_hold_i && (cnt >= CW'(1));
  assign head1_vld_o  = !deq_hold_i && (cnt >= CW'(2));

  // R4: hold masks both head slots
  p_hold_masks_r4: assert property (@(posedge clk) disable iff (rst)
    deq_hold_i |-> !head0_vld_o && !head1_vld_o);
  // R7: the younger head slot is never valid alone
  p_head_order_r7: assert property (@(posedge clk) disable iff (rst)
    head1_vld_o |-> head0_vld_o);
  // R3: free count stays in range
  p_free_range_r3: assert property (@(posedge clk) disable iff (rst)
    free_o <= CW'(DEPTH));
endmodule

// File: tb/tb_iq_dual_queue.sv
module tb_iq_dual_queue;
  logic        clk = 0;
  logic        rst = 1;
  logic        flush_i = 0, deq_hold_i = 0;
  logic [1:0]  enq_cnt_i = 0, deq_cnt_i = 0;
  logic [31:0] enq_data0_i = 0, enq_data1_i = 0;
  logic [2:0]  free_o;
  logic [31:0] head0_data_o, head1_data_o;
  logic        head0_vld_o, head1_vld_o;

  int checks = 0, fails = 0;
  logic [31:0] q[$];
  logic [31:0] seq = 32'hA000_0000;

  iq_dual_queue dut (.*);

  always #2 clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int n = q.size();
    chk(tag, "free", 32'(free_o), 32'(6 - n));
    chk(tag, "vld0", 32'(head0_vld_o), 32'(!deq_hold_i && n >= 1));
    chk(tag, "vld1", 32'(head1_vld_o), 32'(!deq_hold_i && n >= 2));
    if (n >= 1) chk(tag, "head0", head0_data_o, q[0]);
    if (n >= 2) chk(tag, "head1", head1_data_o, q[1]);
  endtask

  // one clock: drive, take the edge, update model, compare
  task automatic cyc(string tag, int enq, int deq, bit hold, bit fl);
    logic [31:0] d0 = seq, d1 = seq + 1;
    seq += 2;
    enq_cnt_i = 2'(enq); deq_cnt_i = 2'(deq); deq_hold_i = hold; flush_i = fl;
    enq_data0_i = d0; enq_data1_i = d1;
    @(posedge clk); #1;
    if (fl) q.delete();
    else begin
      if (!hold) for (int i = 0; i < deq; i++) void'(q.pop_front());
      if (enq >= 1) q.push_back(d0);
      if (enq == 2) q.push_back(d1);
    end
    enq_cnt_i = 0; deq_cnt_i = 0; flush_i = 0;
    compare(tag);
  endtask

  task automatic t_reset;
    rst = 1; q.delete();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    compare("R1");
  endtask

  task automatic t_fill;
    cyc("R2", 1, 0, 0, 0);
    cyc("R2", 2, 0, 0, 0);
    cyc("R3", 2, 0, 0, 0);
    cyc("R3", 1, 0, 0, 0);   // full: free 0
    cyc("R3", 0, 0, 0, 0);
  endtask

  task automatic t_hold;
    cyc("R4", 0, 2, 1, 0);   // dispatch count ignored
    deq_hold_i = 0; #1;
    compare("R4");
  endtask

  task automatic t_drain;
    cyc("R5", 0, 1, 0, 0);
    cyc("R5", 0, 2, 0, 0);
    cyc("R5", 0, 2, 0, 0);
    cyc("R5", 0, 1, 0, 0);   // empty
  endtask

  task automatic t_mix;
    cyc("R6", 2, 0, 0, 0);
    cyc("R6", 2, 1, 0, 0);
    cyc("R6", 1, 2, 0, 0);
    cyc("R6", 2, 2, 0, 0);
    cyc("R6", 0, 2, 0, 0);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 24; i++) begin
      int n = q.size();
      int deq = (n >= 2) ? 2 : n;
      int enq = (6 - n >= 2) ? 2 : 6 - n;
      if (i % 5 == 3) deq = (n >= 1) ? 1 : 0;
      if (i % 7 == 4) enq = (6 - n >= 1) ? 1 : 0;
      cyc("R7", enq, deq, 0, 0);
    end
  endtask

  task automatic t_flush;
    cyc("R8", 2, 0, 0, 0);
    cyc("R8", 2, 1, 0, 1);   // flush drops same-cycle enqueue
    cyc("R8", 1, 0, 0, 0);   // refill after flush starts at the flushed state
    cyc("R8", 0, 0, 0, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_fill();
        t_hold();
        t_drain();
        t_mix();
        t_wrap();
        t_flush();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule